// File: doc/BRIEF.md
# SMBus Write Receiver with Packet Error Check

This block is the receive half of an SMBus/I2C target. It watches open-drain SCL and SDA lines through synchronizers and recognises START, repeated START and STOP. It matches a 7-bit own address in write direction and takes in the data bytes that follow. It pulls a line low only to acknowledge or to stretch the clock, and never drives a line high.

Firmware drives it through a small register-style port. One write strobe loads a byte count together with three mode bits: count reload, packet-error-code transfer and negative acknowledge. Three one-cycle strobes acknowledge the address flag, acknowledge the stop flag and consume the received byte. The block holds SCL low after an address match, and again whenever a reloading count runs out, until firmware answers. A transfer of N data bytes plus a check byte is set up with a count of N+1 and the check-byte mode. The final counted byte is then compared against a CRC-8 that the block keeps over the address byte and every data byte.

Top module: `smb_pec_slave`

## Requirements
- R1: A received address byte whose upper seven bits equal `own_addr` and whose bit 0 (direction) is 0 is acknowledged (SDA low in the ninth clock) and sets `flag_addr`. Any other address byte is not acknowledged and sets no flag.
- R2: After an address match, `scl_oe` is held high (SCL pulled low) until a pulse on `addr_clr`. That pulse clears `flag_addr` and `flag_pecerr`.
- R3: Every accepted data byte, including the check byte, appears on `rx_data` and sets `flag_rxf`. A pulse on `rx_rd` clears `flag_rxf`.
- R4: With the loaded negative-acknowledge bit at 0, each accepted data byte is acknowledged. With it at 1, the byte is still stored but is not acknowledged.
- R5: When the count is 1 on arrival of a byte, reload is off, the check-byte mode is on and `pec_chk_en` is 1, the byte is compared with a CRC-8. The CRC uses polynomial 0x07 and initial value 0x00, and is computed MSB-first over the address byte and all earlier data bytes. On a mismatch the byte is not acknowledged and `flag_pecerr` is set.
- R6: With `pec_chk_en` at 0, a wrong check byte is acknowledged and `flag_pecerr` stays 0.
- R7: When the count is 1 on arrival of a byte and reload is on, the count reaches zero, `flag_reload` is set and SCL is held low. A `ctrl_wr` pulse then loads a new count and mode, clears `flag_reload` and releases SCL.
- R8: When the count reaches zero without reload, the counted transfer ends. Later bytes are not acknowledged and do not touch `flag_rxf` or `rx_data`.
- R9: A STOP after an address match sets `flag_stop` and releases both lines. A pulse on `stop_clr` clears `flag_stop`. A STOP with no match sets nothing.
- R10: A START or repeated START restarts the CRC at its initial value and clears the byte count, so the check byte after a repeated START covers only the new address and the bytes after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_oe | output | 1 | 1 pulls SCL low (clock stretch) |
| sda_oe | output | 1 | 1 pulls SDA low (acknowledge) |
| own_addr | input | 7 | Own 7-bit target address |
| pec_chk_en | input | 1 | Enables comparison of the check byte |
| ctrl_wr | input | 1 | Load strobe for count and mode bits |
| ctrl_cnt | input | CNT_W | Byte count to load |
| ctrl_reload | input | 1 | Reload mode bit to load |
| ctrl_pec_xfer | input | 1 | Check-byte mode bit to load |
| ctrl_nack | input | 1 | Negative-acknowledge bit to load |
| addr_clr | input | 1 | Clears the address flag and releases the stretch |
| stop_clr | input | 1 | Clears the stop flag |
| rx_rd | input | 1 | Consumes the received byte |
| rx_data | output | 8 | Last accepted byte |
| flag_addr | output | 1 | Address matched |
| flag_rxf | output | 1 | Receive byte waiting |
| flag_reload | output | 1 | Count ran out in reload mode |
| flag_stop | output | 1 | STOP seen after a match |
| flag_pecerr | output | 1 | Check byte mismatch |

## Verification
The bound checker watches several rules on every cycle. A rising address or reload flag must come with SCL held low, and a rising check-error flag must come with no acknowledge driven. A rising stop flag must find both lines released. The receive, reload and stop flags may only fall one cycle after their own clearing strobe. Only the bench's bus-level scenarios can show the rest: which address bytes are acknowledged, the byte values delivered, the CRC value that counts as correct, stretching that lasts until firmware answers, the end of a counted transfer and the CRC restart on a repeated START.

// File: rtl/smb_pkg.sv
package smb_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,   // bus free or not addressed
        ST_BITS,   // shifting in eight bits
        ST_ACK,    // ninth clock, optional low drive on SDA
        ST_WAIT    // ignore everything until START or STOP
    } rx_state_e;

    localparam int BYTE_W = 8;

endpackage

// File: rtl/smb_sync.sv
module smb_sync #(
    parameter int STAGES = 2,
    parameter int WIDTH  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    logic [STAGES-1:0][WIDTH-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '1;
        end else begin
            chain_q[0] <= d_i;
            for (int s = 1; s < STAGES; s++) begin
                chain_q[s] <= chain_q[s-1];
            end
        end
    end

    assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/smb_cond_det.sv
module smb_cond_det (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_s,
    input  logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic scl_prev_d, scl_prev_q;
    logic sda_prev_d, sda_prev_q;

    always_comb begin
        scl_prev_d = scl_s;
        sda_prev_d = sda_s;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_prev_q <= 1'b1;
            sda_prev_q <= 1'b1;
        end else begin
            scl_prev_q <= scl_prev_d;
            sda_prev_q <= sda_prev_d;
        end
    end

    assign scl_rise  = scl_s & ~scl_prev_q;
    assign scl_fall  = ~scl_s & scl_prev_q;
    // SDA moving while SCL stays high marks a bus condition
    assign start_det = scl_s & scl_prev_q & sda_prev_q & ~sda_s;
    assign stop_det  = scl_s & scl_prev_q & ~sda_prev_q & sda_s;

endmodule

// File: rtl/smb_crc8.sv
module smb_crc8 #(
    parameter logic [7:0] POLY = 8'h07
) (
    input  logic [7:0] crc_i,
    input  logic [7:0] byte_i,
    output logic [7:0] crc_o
);
    always_comb begin
        logic [7:0] acc;
        logic       fb;
        acc = crc_i;
        for (int b = 7; b >= 0; b--) begin
            fb  = acc[7] ^ byte_i[b];
            acc = {acc[6:0], 1'b0} ^ (fb ? POLY : 8'h00);
        end
        crc_o = acc;
    end

endmodule

// File: rtl/smb_pec_slave.sv
module smb_pec_slave #(
    parameter int         CNT_W       = 8,
    parameter int         SYNC_STAGES = 2,
    parameter logic [7:0] PEC_POLY    = 8'h07,
    parameter logic [7:0] PEC_INIT    = 8'h00
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_i,
    input  logic             sda_i,
    output logic             scl_oe,
    output logic             sda_oe,
    input  logic [6:0]       own_addr,
    input  logic             pec_chk_en,
    input  logic             ctrl_wr,
    input  logic [CNT_W-1:0] ctrl_cnt,
    input  logic             ctrl_reload,
    input  logic             ctrl_pec_xfer,
    input  logic             ctrl_nack,
    input  logic             addr_clr,
    input  logic             stop_clr,
    input  logic             rx_rd,
    output logic [7:0]       rx_data,
    output logic             flag_addr,
    output logic             flag_rxf,
    output logic             flag_reload,
    output logic             flag_stop,
    output logic             flag_pecerr
);
    import smb_pkg::*;

    localparam int BIT_CW = $clog2(BYTE_W + 1);
    localparam logic [BIT_CW-1:0] BITS_FULL = BIT_CW'(BYTE_W);
    localparam logic [CNT_W-1:0]  CNT_ONE   = CNT_W'(1);

    typedef struct packed {
        rx_state_e          st;
        logic [BIT_CW-1:0]  bit_cnt;
        logic [7:0]         shreg;
        logic               is_addr;
        logic               active;
        logic               done;
        logic               sda_drv;
        logic               str_addr;
        logic               str_rld;
        logic [CNT_W-1:0]   cnt;
        logic               reload;
        logic               pecx;
        logic               nack;
        logic [7:0]         crc;
        logic [7:0]         rxd;
        logic               f_addr;
        logic               f_rxf;
        logic               f_rld;
        logic               f_stop;
        logic               f_pec;
    } rx_regs_t;

    rx_regs_t d, q;

    logic [1:0] line_raw, line_s;
    logic       scl_s, sda_s;
    logic       scl_rise, scl_fall, start_det, stop_det;
    logic [7:0] crc_next;

    assign line_raw = {scl_i, sda_i};

    smb_sync #(
        .STAGES (SYNC_STAGES),
        .WIDTH  (2)
    ) i_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (line_raw),
        .q_o   (line_s)
    );

    assign scl_s = line_s[1];
    assign sda_s = line_s[0];

    smb_cond_det i_cond (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    smb_crc8 #(
        .POLY (PEC_POLY)
    ) i_crc (
        .crc_i  (q.crc),
        .byte_i (q.shreg),
        .crc_o  (crc_next)
    );

    always_comb begin
        logic give_ack;
        d        = q;
        give_ack = 1'b0;

        // firmware side
        if (rx_rd) d.f_rxf = 1'b0;
        if (addr_clr) begin
            d.f_addr   = 1'b0;
            d.str_addr = 1'b0;
            d.f_pec    = 1'b0;
        end
        if (stop_clr) d.f_stop = 1'b0;
        if (ctrl_wr) begin
            d.cnt     = ctrl_cnt;
            d.reload  = ctrl_reload;
            d.pecx    = ctrl_pec_xfer;
            d.nack    = ctrl_nack;
            d.f_rld   = 1'b0;
            d.str_rld = 1'b0;
        end

        // bus side
        if (stop_det) begin
            d.st       = ST_IDLE;
            d.f_stop   = q.active | d.f_stop;
            d.active   = 1'b0;
            d.sda_drv  = 1'b0;
            d.str_addr = 1'b0;
            d.str_rld  = 1'b0;
            d.crc      = PEC_INIT;
            d.done     = 1'b0;
            d.cnt      = '0;
        end else if (start_det) begin
            d.st       = ST_BITS;
            d.bit_cnt  = '0;
            d.is_addr  = 1'b1;
            d.active   = 1'b0;
            d.sda_drv  = 1'b0;
            d.str_addr = 1'b0;
            d.str_rld  = 1'b0;
            d.crc      = PEC_INIT;
            d.done     = 1'b0;
            d.cnt      = '0;
        end else begin
            unique case (q.st)
                ST_BITS: begin
                    if (scl_rise && q.bit_cnt != BITS_FULL) begin
                        d.shreg   = {q.shreg[6:0], sda_s};
                        d.bit_cnt = q.bit_cnt + 1'b1;
                    end else if (scl_fall && q.bit_cnt == BITS_FULL) begin
                        if (q.is_addr) begin
                            if (q.shreg[7:1] == own_addr && !q.shreg[0]) begin
                                d.f_addr   = 1'b1;
                                d.str_addr = 1'b1;
                                d.sda_drv  = 1'b1;
                                d.active   = 1'b1;
                                d.crc      = crc_next;
                                d.st       = ST_ACK;
                            end else begin
                                d.st = ST_WAIT;
                            end
                        end else if (q.done) begin
                            d.st = ST_WAIT;
                        end else begin
                            d.rxd    = q.shreg;
                            d.f_rxf  = 1'b1;
                            d.crc    = crc_next;
                            give_ack = ~q.nack;
                            if (q.cnt == CNT_ONE) begin
                                d.cnt = '0;
                                if (q.reload) begin
                                    d.f_rld   = 1'b1;
                                    d.str_rld = 1'b1;
                                end else begin
                                    d.done = 1'b1;
                                    if (q.pecx && pec_chk_en && q.shreg != q.crc) begin
                                        give_ack = 1'b0;
                                        d.f_pec  = 1'b1;
                                    end
                                end
                            end else if (q.cnt != '0) begin
                                d.cnt = q.cnt - 1'b1;
                            end
                            d.sda_drv = give_ack;
                            d.st      = ST_ACK;
                        end
                    end
                end
                ST_ACK: begin
                    if (scl_fall) begin
                        d.st      = q.sda_drv ? ST_BITS : ST_WAIT;
                        d.bit_cnt = '0;
                        d.is_addr = 1'b0;
                        d.sda_drv = 1'b0;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.st    <= ST_IDLE;
            q.crc   <= PEC_INIT;
        end else begin
            q <= d;
        end
    end

    assign scl_oe      = q.str_addr | q.str_rld;
    assign sda_oe      = q.sda_drv;
    assign rx_data     = q.rxd;
    assign flag_addr   = q.f_addr;
    assign flag_rxf    = q.f_rxf;
    assign flag_reload = q.f_rld;
    assign flag_stop   = q.f_stop;
    assign flag_pecerr = q.f_pec;

endmodule

// File: rtl/smb_pec_slave_chk.sv
module smb_pec_slave_chk (
    input logic clk,
    input logic rst_n,
    input logic scl_oe,
    input logic sda_oe,
    input logic ctrl_wr,
    input logic addr_clr,
    input logic stop_clr,
    input logic rx_rd,
    input logic flag_addr,
    input logic flag_rxf,
    input logic flag_reload,
    input logic flag_stop,
    input logic flag_pecerr
);
    p_addr_stretch_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_addr) |-> scl_oe);

    p_addr_release_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flag_addr) |-> $past(addr_clr));

    p_rxf_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flag_rxf) |-> $past(rx_rd));

    p_pec_nack_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_pecerr) |-> !sda_oe);

    p_reload_stretch_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_reload) |-> scl_oe);

    p_reload_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flag_reload) |-> $past(ctrl_wr));

    p_stop_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_stop) |-> (!scl_oe && !sda_oe));

    p_stop_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flag_stop) |-> $past(stop_clr));

endmodule

bind smb_pec_slave smb_pec_slave_chk i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .scl_oe      (scl_oe),
    .sda_oe      (sda_oe),
    .ctrl_wr     (ctrl_wr),
    .addr_clr    (addr_clr),
    .stop_clr    (stop_clr),
    .rx_rd       (rx_rd),
    .flag_addr   (flag_addr),
    .flag_rxf    (flag_rxf),
    .flag_reload (flag_reload),
    .flag_stop   (flag_stop),
    .flag_pecerr (flag_pecerr)
);

// File: tb/test_smb_pec_slave.sv
module test_smb_pec_slave;
    localparam int         HALF = 12;
    localparam int         QTR  = 6;
    localparam logic [6:0] OWN  = 7'h3A;

    // {address, data0, data1, corrupt check byte}
    localparam logic [23:0] VEC [5] = '{
        {7'h3A, 8'hA5, 8'h3C, 1'b0},
        {7'h3A, 8'h00, 8'hFF, 1'b1},
        {7'h21, 8'h11, 8'h22, 1'b0},
        {7'h3A, 8'h80, 8'h01, 1'b0},
        {7'h3B, 8'h3A, 8'h74, 1'b0}
    };

    logic clk = 1'b0, rst_n = 1'b0;
    logic scl_m = 1'b1, sda_m = 1'b1;
    logic scl_oe, sda_oe, scl_line, sda_line;
    logic pec_chk_en = 1'b1;
    logic ctrl_wr = 1'b0, ctrl_reload = 1'b0, ctrl_pec_xfer = 1'b0, ctrl_nack = 1'b0;
    logic [7:0] ctrl_cnt = '0;
    logic addr_clr = 1'b0, stop_clr = 1'b0, rx_rd = 1'b0;
    logic [7:0] rx_data;
    logic flag_addr, flag_rxf, flag_reload, flag_stop, flag_pecerr;
    int n_tests = 0, n_fail = 0;

    always #10 clk = ~clk;

    assign scl_line = scl_m & ~scl_oe;
    assign sda_line = sda_m & ~sda_oe;

    smb_pec_slave i_smb_pec_slave (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_line), .sda_i(sda_line),
        .scl_oe(scl_oe), .sda_oe(sda_oe), .own_addr(OWN), .pec_chk_en(pec_chk_en),
        .ctrl_wr(ctrl_wr), .ctrl_cnt(ctrl_cnt), .ctrl_reload(ctrl_reload),
        .ctrl_pec_xfer(ctrl_pec_xfer), .ctrl_nack(ctrl_nack), .addr_clr(addr_clr),
        .stop_clr(stop_clr), .rx_rd(rx_rd), .rx_data(rx_data), .flag_addr(flag_addr),
        .flag_rxf(flag_rxf), .flag_reload(flag_reload), .flag_stop(flag_stop),
        .flag_pecerr(flag_pecerr)
    );

    function automatic logic [7:0] crc8(input logic [7:0] c, input logic [7:0] b);
        logic [7:0] r = c;
        for (int i = 7; i >= 0; i--) begin
            if (r[7] ^ b[i]) r = {r[6:0], 1'b0} ^ 8'h07;
            else             r = {r[6:0], 1'b0};
        end
        return r;
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_scl_high();
        wait (scl_line == 1'b1);
        @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b0; cyc(HALF); scl_m = 1'b0; cyc(HALF);
    endtask

    task automatic bus_rep_start();
        cyc(QTR); sda_m = 1'b1; cyc(HALF); scl_m = 1'b1; wait_scl_high();
        cyc(HALF); sda_m = 1'b0; cyc(HALF); scl_m = 1'b0; cyc(HALF);
    endtask

    task automatic bus_stop();
        cyc(QTR); sda_m = 1'b0; cyc(HALF); scl_m = 1'b1; wait_scl_high();
        cyc(HALF); sda_m = 1'b1; cyc(HALF);
    endtask

    task automatic send_bits(input logic [7:0] b);
        for (int i = 7; i >= 0; i--) begin
            cyc(QTR); sda_m = b[i]; cyc(HALF);
            scl_m = 1'b1; wait_scl_high(); cyc(HALF); scl_m = 1'b0;
        end
        cyc(6);
    endtask

    task automatic ack_clock(output bit ack);
        cyc(QTR); sda_m = 1'b1; cyc(HALF);
        scl_m = 1'b1; wait_scl_high(); cyc(3);
        ack = !sda_line;
        cyc(HALF); scl_m = 1'b0;
    endtask

    task automatic sw_ctrl(input logic [7:0] c, input bit rl, input bit px, input bit nk);
        ctrl_cnt = c; ctrl_reload = rl; ctrl_pec_xfer = px; ctrl_nack = nk;
        ctrl_wr = 1'b1; cyc(1); ctrl_wr = 1'b0; cyc(1);
    endtask

    task automatic pulse_addr_clr(); addr_clr = 1'b1; cyc(1); addr_clr = 1'b0; cyc(1); endtask
    task automatic pulse_stop_clr(); stop_clr = 1'b1; cyc(1); stop_clr = 1'b0; cyc(1); endtask
    task automatic pulse_rd();       rx_rd = 1'b1;    cyc(1); rx_rd = 1'b0;    cyc(1); endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog expired actual=hung expected=done");
        summary();
        $finish;
    end

    initial begin : main
        bit ack;
        logic [7:0] crc, pec;
        cyc(3); rst_n = 1'b1; cyc(3);

        // reset state
        chk("R2 reset scl_oe", scl_oe, 0);
        chk("R1 reset sda_oe", sda_oe, 0);
        chk("R1 reset flags", {flag_addr, flag_rxf, flag_reload, flag_stop, flag_pecerr}, 0);

        // vector table
        for (int v = 0; v < 5; v++) begin
            logic [23:0] e;
            bit match;
            e = VEC[v];
            match = (e[23:17] == OWN);
            bus_start();
            send_bits({e[23:17], 1'b0});
            chk("R1 address flag", flag_addr, match);
            if (match) begin
                chk("R2 stretch at match", scl_oe, 1);
                sw_ctrl(8'd3, 1'b0, 1'b1, 1'b0);
                pulse_addr_clr();
                chk("R2 stretch released", scl_oe, 0);
                chk("R2 pec flag cleared", flag_pecerr, 0);
            end
            ack_clock(ack);
            chk("R1 address ack", ack, match);
            if (match) begin
                crc = crc8(8'h00, {e[23:17], 1'b0});
                for (int k = 0; k < 2; k++) begin
                    logic [7:0] db;
                    db = (k == 0) ? e[16:9] : e[8:1];
                    send_bits(db);
                    chk("R3 rxf set", flag_rxf, 1);
                    chk("R3 rx_data", rx_data, db);
                    pulse_rd();
                    chk("R3 rxf cleared", flag_rxf, 0);
                    ack_clock(ack);
                    chk("R4 data ack", ack, 1);
                    crc = crc8(crc, db);
                end
                pec = crc ^ (e[0] ? 8'h01 : 8'h00);
                send_bits(pec);
                chk("R3 check byte stored", rx_data, pec);
                chk("R5 pec error flag", flag_pecerr, e[0]);
                pulse_rd();
                ack_clock(ack);
                chk("R5 check byte ack", ack, !e[0]);
                bus_stop(); cyc(6);
                chk("R9 stop flag", flag_stop, 1);
                chk("R9 lines released", {scl_oe, sda_oe}, 0);
                pulse_stop_clr();
                chk("R9 stop cleared", flag_stop, 0);
            end else begin
                bus_stop(); cyc(6);
                chk("R9 no stop flag unaddressed", flag_stop, 0);
            end
        end

        // R2 stretch really holds the bus; R7 byte-by-byte reload
        bus_start();
        send_bits({OWN, 1'b0});
        fork
            ack_clock(ack);
            begin
                cyc(60);
                chk("R2 scl held low", scl_line, 0);
                sw_ctrl(8'd1, 1'b1, 1'b1, 1'b0);
                pulse_addr_clr();
            end
        join
        chk("R2 ack after release", ack, 1);
        crc = crc8(8'h00, {OWN, 1'b0});
        for (int k = 0; k < 2; k++) begin
            logic [7:0] db;
            db = 8'h5A + 8'(k * 17);
            send_bits(db);
            chk("R7 reload flag", flag_reload, 1);
            chk("R7 reload stretch", scl_oe, 1);
            chk("R3 rx_data byte mode", rx_data, db);
            pulse_rd();
            sw_ctrl(8'd1, (k == 0), 1'b1, 1'b0);
            chk("R7 reload cleared", flag_reload, 0);
            chk("R7 stretch released", scl_oe, 0);
            ack_clock(ack);
            chk("R4 byte mode ack", ack, 1);
            crc = crc8(crc, db);
        end
        send_bits(crc);
        chk("R7 no reload on final", flag_reload, 0);
        chk("R5 final check byte ok", flag_pecerr, 0);
        pulse_rd();
        ack_clock(ack);
        chk("R5 final ack", ack, 1);
        bus_stop(); cyc(6); pulse_stop_clr();

        // R4 negative acknowledge
        bus_start(); send_bits({OWN, 1'b0});
        sw_ctrl(8'd3, 1'b0, 1'b1, 1'b1); pulse_addr_clr(); ack_clock(ack);
        send_bits(8'hC3);
        chk("R4 nack byte stored", flag_rxf, 1);
        ack_clock(ack);
        chk("R4 nack enabled", ack, 0);
        pulse_rd();
        bus_stop(); cyc(6);
        chk("R9 stop after nack", flag_stop, 1);
        pulse_stop_clr();

        // R6 checking disabled
        pec_chk_en = 1'b0;
        bus_start(); send_bits({OWN, 1'b0});
        sw_ctrl(8'd2, 1'b0, 1'b1, 1'b0); pulse_addr_clr(); ack_clock(ack);
        crc = crc8(crc8(8'h00, {OWN, 1'b0}), 8'h42);
        send_bits(8'h42); pulse_rd(); ack_clock(ack);
        send_bits(crc ^ 8'hFF);
        chk("R6 no pec error", flag_pecerr, 0);
        pulse_rd(); ack_clock(ack);
        chk("R6 wrong byte acked", ack, 1);
        bus_stop(); cyc(6); pulse_stop_clr();
        pec_chk_en = 1'b1;

        // R10 repeated START restarts CRC; R8 bytes after end refused
        bus_start(); send_bits({OWN, 1'b0});
        sw_ctrl(8'd3, 1'b0, 1'b1, 1'b0); pulse_addr_clr(); ack_clock(ack);
        send_bits(8'h55); pulse_rd(); ack_clock(ack);
        bus_rep_start();
        send_bits({OWN, 1'b0});
        chk("R10 re-addressed", flag_addr, 1);
        sw_ctrl(8'd2, 1'b0, 1'b1, 1'b0); pulse_addr_clr(); ack_clock(ack);
        crc = crc8(crc8(8'h00, {OWN, 1'b0}), 8'h12);
        send_bits(8'h12); pulse_rd(); ack_clock(ack);
        send_bits(crc);
        chk("R10 crc restarted", flag_pecerr, 0);
        pulse_rd(); ack_clock(ack);
        chk("R10 check ack", ack, 1);
        send_bits(8'h99);
        chk("R8 extra byte not stored", flag_rxf, 0);
        chk("R8 rx_data kept", rx_data, crc);
        ack_clock(ack);
        chk("R8 extra byte nacked", ack, 0);
        bus_stop(); cyc(6); pulse_stop_clr();

        summary();
        $finish;
    end

endmodule